// File: doc/BRIEF.md
# Serial Command Frame CRC Checker

This block sits behind the receiver of a serial sensor bus and takes in one command frame at a time, one bit per strobe. A 4-bit CRC is advanced as each bit arrives, so the verdict is available as soon as the frame-end marker is seen. The last four bits of any frame are the transmitted check value. They are held apart from the running CRC and compared against it when the frame closes.

The frame length, together with a mode flag sampled at frame start, identifies the frame as long, standard short, 8-bit enhanced short or 10-bit enhanced short. On a match the block raises a one-cycle strobe and registers the data, address and command fields and a type code. A frame with a bad check value, or with a length it does not recognise, is dropped without any indication. In standard mode the CRC is fixed. In enhanced mode the generator and the starting value come from configuration inputs.

Top module: `cmd_crc_checker`

## Requirements
- R1: After reset, cmd_valid is 0 and cmd_type, cmd_data, cmd_addr and cmd_cmd are all zero.
- R2: The CRC register loads a seed at frame start. For every frame bit except the last four, in arrival order, fb = crc[3] XOR bit, and the next crc is (crc shifted left by one, zero filled) XOR (fb ? poly : 0). In standard mode poly = 4'b0001 and seed = 4'b1010, whatever the configuration inputs hold. In enhanced mode they are poly_cfg and seed_cfg.
- R3: When the computed CRC differs from the last four frame bits (first received bit as MSB), no strobe is produced and all output fields keep their previous values.
- R4: A 20-bit frame is 8 data bits, then 4 address bits, then 4 command bits, then 4 CRC bits, each field MSB first. It is accepted in either mode with cmd_type = 0 and cmd_data = the 8 data bits.
- R5: A 12-bit frame (4 address, 4 command, 4 CRC) in standard mode is accepted with cmd_type = 1 and cmd_data = 0.
- R6: A 12-bit frame in enhanced mode is accepted with cmd_type = 2 and cmd_data = 0.
- R7: A 14-bit frame in enhanced mode (2 optional data bits, then address, command and CRC) is accepted with cmd_type = 3 and cmd_data = {6'b0, the two optional bits}.
- R8: A frame of any length other than 12, 14 or 20 bits, and a 14-bit frame in standard mode, is discarded: no strobe, and the fields are unchanged.
- R9: cmd_valid is high for exactly one cycle, in the cycle after the clock edge that samples frm_end. The fields change only together with that pulse.
- R10: A frm_start during a frame abandons the frame and starts a new one. frm_start takes priority over frm_end and bit_en in the same cycle.
- R11: enh_mode, poly_cfg and seed_cfg are sampled only in the frm_start cycle. Changing them later in the frame has no effect on its result.
- R12: bit_en and frm_end are ignored when no frame is open. A frame is open from frm_start until the next frm_end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_start | input | 1 | Opens a new frame (aborts any open one) |
| frm_end | input | 1 | Closes the open frame and triggers evaluation |
| bit_en | input | 1 | Qualifies bit_val as one received frame bit |
| bit_val | input | 1 | Received bit value |
| enh_mode | input | 1 | Enhanced mode select, sampled at frame start |
| poly_cfg | input | 4 | Programmed generator bits x^3..x^0 (x^4 implied) |
| seed_cfg | input | 4 | Programmed CRC start value |
| cmd_valid | output | 1 | One-cycle strobe for an accepted frame |
| cmd_type | output | 2 | 0 long, 1 short, 2 enhanced short 8, 3 enhanced short 10 |
| cmd_data | output | 8 | Data field of the last accepted frame |
| cmd_addr | output | 4 | Address field of the last accepted frame |
| cmd_cmd | output | 4 | Command field of the last accepted frame |

## Verification
A corrupted CRC register, or a wrong point where bits stop feeding it, shows as a missing or spurious strobe at the close of the very next frame. A bit counter or shift register that is off shows as a wrong type code or shifted fields on that same strobe. A stuck open-frame flag or latched mode shows as strobes from stray end markers, or as a wrong type, within one frame. The sweeps cover every address/command pair in each short format, every optional-bit combination, and many generator and seed values, so a wrong state reaches the ports within a few hundred cycles.

// File: rtl/cmd_crc_pkg.sv
`timescale 1ns/1ps
package cmd_crc_pkg;
    localparam int CRC_W  = 4;
    localparam int FLD_W  = 4;
    localparam int DATA_W = 8;
    localparam int OPT_W  = 2;

    localparam logic [CRC_W-1:0] STD_POLY = 4'b0001;
    localparam logic [CRC_W-1:0] STD_SEED = 4'b1010;

    typedef enum logic [1:0] {
        FT_LONG  = 2'd0,
        FT_SHORT = 2'd1,
        FT_ESW8  = 2'd2,
        FT_ESW10 = 2'd3
    } frame_type_e;
endpackage

// File: rtl/cmd_crc_serial.sv
`timescale 1ns/1ps
// Bit-serial CRC register: load a seed, then advance once per fed bit.
module cmd_crc_serial #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic [W-1:0] poly,
    input  logic         feed_en,
    input  logic         feed_bit,
    output logic [W-1:0] crc
);
    typedef struct packed {
        logic [W-1:0] crc;
    } crc_st_t;

    crc_st_t st_d, st_q;
    logic    fb;

    always_comb begin
        st_d = st_q;
        fb   = st_q.crc[W-1] ^ feed_bit;
        if (load) begin
            st_d.crc = seed;
        end else if (feed_en) begin
            st_d.crc = {st_q.crc[W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc = st_q.crc;
endmodule

// File: rtl/cmd_bit_collect.sv
`timescale 1ns/1ps
// Frame bit shift register plus saturating bit counter.
module cmd_bit_collect #(
    parameter int SH_W  = 20,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [SH_W-1:0]  sh,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [SH_W-1:0]  sh;
        logic [CNT_W-1:0] cnt;
    } col_st_t;

    col_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (shift_en) begin
            st_d.sh = {st_q.sh[SH_W-2:0], bit_in};
            if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sh  = st_q.sh;
    assign cnt = st_q.cnt;
endmodule

// File: rtl/cmd_frame_decode.sv
`timescale 1ns/1ps
// Classifies a closed frame by length and mode, checks CRC, extracts fields.
module cmd_frame_decode
    import cmd_crc_pkg::*;
#(
    parameter int CRC_W  = 4,
    parameter int FLD_W  = 4,
    parameter int DATA_W = 8,
    parameter int OPT_W  = 2,
    parameter int CNT_W  = 5
) (
    input  logic [CRC_W+2*FLD_W+DATA_W-1:0] sh,
    input  logic [CNT_W-1:0]                cnt,
    input  logic                            enh,
    input  logic [CRC_W-1:0]                crc_calc,
    output logic                            ok,
    output frame_type_e                     ftype,
    output logic [DATA_W-1:0]               data,
    output logic [FLD_W-1:0]                addr,
    output logic [FLD_W-1:0]                cmd
);
    localparam int DB        = CRC_W + 2*FLD_W;
    localparam int LEN_SHORT = DB;
    localparam int LEN_OPT   = DB + OPT_W;
    localparam int LEN_LONG  = DB + DATA_W;

    logic len_ok;

    always_comb begin
        len_ok = 1'b0;
        ftype  = FT_LONG;
        data   = '0;
        if (cnt == CNT_W'(LEN_LONG)) begin
            len_ok = 1'b1;
            ftype  = FT_LONG;
            data   = sh[DB +: DATA_W];
        end else if (cnt == CNT_W'(LEN_SHORT)) begin
            len_ok = 1'b1;
            ftype  = enh ? FT_ESW8 : FT_SHORT;
        end else if (enh && (cnt == CNT_W'(LEN_OPT))) begin
            len_ok = 1'b1;
            ftype  = FT_ESW10;
            data[OPT_W-1:0] = sh[DB +: OPT_W];
        end
    end

    assign addr = sh[CRC_W+FLD_W +: FLD_W];
    assign cmd  = sh[CRC_W +: FLD_W];
    assign ok   = len_ok && (crc_calc == sh[CRC_W-1:0]);
endmodule

// File: rtl/cmd_crc_checker.sv
`timescale 1ns/1ps
module cmd_crc_checker
    import cmd_crc_pkg::*;
#(
    parameter int CRC_WIDTH  = cmd_crc_pkg::CRC_W,
    parameter int FLD_WIDTH  = cmd_crc_pkg::FLD_W,
    parameter int DATA_WIDTH = cmd_crc_pkg::DATA_W,
    parameter int OPT_WIDTH  = cmd_crc_pkg::OPT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frm_start,
    input  logic                  frm_end,
    input  logic                  bit_en,
    input  logic                  bit_val,
    input  logic                  enh_mode,
    input  logic [CRC_WIDTH-1:0]  poly_cfg,
    input  logic [CRC_WIDTH-1:0]  seed_cfg,
    output logic                  cmd_valid,
    output logic [1:0]            cmd_type,
    output logic [DATA_WIDTH-1:0] cmd_data,
    output logic [FLD_WIDTH-1:0]  cmd_addr,
    output logic [FLD_WIDTH-1:0]  cmd_cmd
);
    localparam int SH_W  = CRC_WIDTH + 2*FLD_WIDTH + DATA_WIDTH;
    localparam int CNT_W = $clog2(SH_W + 2);

    typedef struct packed {
        logic                  active;
        logic                  enh;
        logic [CRC_WIDTH-1:0]  poly;
        logic                  valid;
        frame_type_e           ftype;
        logic [DATA_WIDTH-1:0] data;
        logic [FLD_WIDTH-1:0]  addr;
        logic [FLD_WIDTH-1:0]  cmd;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                  accept_bit;
    logic                  end_evt;
    logic                  feed_en;
    logic [CRC_WIDTH-1:0]  seed_sel;
    logic [SH_W-1:0]       sh;
    logic [CNT_W-1:0]      cnt;
    logic [CRC_WIDTH-1:0]  crc_calc;
    logic                  dec_ok;
    frame_type_e           dec_type;
    logic [DATA_WIDTH-1:0] dec_data;
    logic [FLD_WIDTH-1:0]  dec_addr;
    logic [FLD_WIDTH-1:0]  dec_cmd;
    logic                  frame_enh;

    assign accept_bit = st_q.active && bit_en && !frm_start && !frm_end;
    assign end_evt    = st_q.active && frm_end && !frm_start;
    assign feed_en    = accept_bit && (cnt >= CNT_W'(CRC_WIDTH));
    assign seed_sel   = enh_mode ? seed_cfg : STD_SEED;

    cmd_bit_collect #(.SH_W(SH_W), .CNT_W(CNT_W)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frm_start),
        .shift_en (accept_bit),
        .bit_in   (bit_val),
        .sh       (sh),
        .cnt      (cnt)
    );

    cmd_crc_serial #(.W(CRC_WIDTH)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frm_start),
        .seed     (seed_sel),
        .poly     (st_q.poly),
        .feed_en  (feed_en),
        .feed_bit (sh[CRC_WIDTH-1]),
        .crc      (crc_calc)
    );

    cmd_frame_decode #(
        .CRC_W  (CRC_WIDTH),
        .FLD_W  (FLD_WIDTH),
        .DATA_W (DATA_WIDTH),
        .OPT_W  (OPT_WIDTH),
        .CNT_W  (CNT_W)
    ) u_decode (
        .sh       (sh),
        .cnt      (cnt),
        .enh      (st_q.enh),
        .crc_calc (crc_calc),
        .ok       (dec_ok),
        .ftype    (dec_type),
        .data     (dec_data),
        .addr     (dec_addr),
        .cmd      (dec_cmd)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (frm_start) begin
            st_d.active = 1'b1;
            st_d.enh    = enh_mode;
            st_d.poly   = enh_mode ? poly_cfg : STD_POLY;
        end else if (end_evt) begin
            st_d.active = 1'b0;
            if (dec_ok) begin
                st_d.valid = 1'b1;
                st_d.ftype = dec_type;
                st_d.data  = dec_data;
                st_d.addr  = dec_addr;
                st_d.cmd   = dec_cmd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{default: '0, ftype: FT_LONG};
        else        st_q <= st_d;
    end

    assign frame_enh = st_q.enh;
    assign cmd_valid = st_q.valid;
    assign cmd_type  = st_q.ftype;
    assign cmd_data  = st_q.data;
    assign cmd_addr  = st_q.addr;
    assign cmd_cmd   = st_q.cmd;
endmodule

// File: rtl/cmd_crc_checker_chk.sv
`timescale 1ns/1ps
module cmd_crc_checker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_end,
    input logic       cmd_valid,
    input logic [1:0] cmd_type,
    input logic [7:0] cmd_data,
    input logic [3:0] cmd_addr,
    input logic [3:0] cmd_cmd,
    input logic       frame_enh
);
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(frm_end));

    p_fields_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable({cmd_type, cmd_data, cmd_addr, cmd_cmd}));

    p_enh_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type[1]) |-> frame_enh);

    p_short_nodata_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == 2'd1) |-> (cmd_data == 8'd0));

    p_opt_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == 2'd3) |-> (cmd_data[7:2] == 6'd0));
endmodule

bind cmd_crc_checker cmd_crc_checker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_end   (frm_end),
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .cmd_data  (cmd_data),
    .cmd_addr  (cmd_addr),
    .cmd_cmd   (cmd_cmd),
    .frame_enh (frame_enh)
);

// File: tb/cmd_crc_checker_bench.sv
`timescale 1ns/1ps
module cmd_crc_checker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_start = 1'b0;
    logic       frm_end = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_val = 1'b0;
    logic       enh_mode = 1'b0;
    logic [3:0] poly_cfg = '0;
    logic [3:0] seed_cfg = '0;
    logic       cmd_valid;
    logic [1:0] cmd_type;
    logic [7:0] cmd_data;
    logic [3:0] cmd_addr;
    logic [3:0] cmd_cmd;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic [17:0] hold_f = '0;   // {type, data, addr, cmd} of last accepted frame

    always #5 clk = ~clk;

    cmd_crc_checker u_cmd_crc_checker (
        .clk (clk), .rst_n (rst_n), .frm_start (frm_start), .frm_end (frm_end),
        .bit_en (bit_en), .bit_val (bit_val), .enh_mode (enh_mode),
        .poly_cfg (poly_cfg), .seed_cfg (seed_cfg), .cmd_valid (cmd_valid),
        .cmd_type (cmd_type), .cmd_data (cmd_data), .cmd_addr (cmd_addr),
        .cmd_cmd (cmd_cmd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] ref_crc(input logic [31:0] pay, input int n,
                                           input logic [3:0] poly, input logic [3:0] seed);
        logic [3:0] c;
        logic       fb;
        c = seed;
        for (int i = n - 1; i >= 0; i--) begin
            fb = c[3] ^ pay[i];
            c  = {c[2:0], 1'b0} ^ (fb ? poly : 4'b0000);
        end
        return c;
    endfunction

    task automatic drive(input logic [31:0] frm, input int n, input bit enh,
                         input logic [3:0] poly, input logic [3:0] seed, input bit scr);
        @(negedge clk);
        frm_start = 1'b1; enh_mode = enh; poly_cfg = poly; seed_cfg = seed;
        @(negedge clk);
        frm_start = 1'b0;
        if (scr) begin
            enh_mode = !enh; poly_cfg = ~poly; seed_cfg = ~seed;
        end
        for (int i = n - 1; i >= 0; i--) begin
            bit_en = 1'b1; bit_val = frm[i];
            @(negedge clk);
        end
        bit_en = 1'b0; frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
    endtask

    task automatic do_frame(input int n, input bit enh, input logic [3:0] poly,
                            input logic [3:0] seed, input logic [31:0] pay,
                            input logic [3:0] corrupt, input bit scr, input string req);
        logic [3:0]  ep, es, c;
        logic [31:0] frm;
        bit          len_ok, exp_v;
        logic [1:0]  et;
        logic [7:0]  ed;
        ep = enh ? poly : 4'b0001;
        es = enh ? seed : 4'b1010;
        c  = (n >= 4) ? (ref_crc(pay, n - 4, ep, es) ^ corrupt) : 4'h0;
        frm = (pay << 4) | {28'd0, c};
        drive(frm, n, enh, poly, seed, scr);
        len_ok = (n == 20) || (n == 12) || (n == 14 && enh);
        exp_v  = len_ok && (corrupt == 4'h0);
        if (exp_v) begin
            et = (n == 20) ? 2'd0 : (n == 12) ? (enh ? 2'd2 : 2'd1) : 2'd3;
            ed = (n == 20) ? pay[15:8] : (n == 14) ? {6'd0, pay[9:8]} : 8'd0;
            hold_f = {et, ed, pay[7:4], pay[3:0]};
        end
        chk(req, {13'd0, cmd_valid, cmd_type, cmd_data, cmd_addr, cmd_cmd},
                 {13'd0, exp_v, hold_f});
        @(negedge clk);
        chk("R9 pulse width", {31'd0, cmd_valid}, 32'd0);
    endtask

    task automatic partial(input int k, input bit enh);
        @(negedge clk);
        frm_start = 1'b1; enh_mode = enh;
        @(negedge clk);
        frm_start = 1'b0;
        for (int i = 0; i < k; i++) begin
            bit_en = 1'b1; bit_val = i[0];
            @(negedge clk);
        end
        bit_en = 1'b0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {13'd0, cmd_valid, cmd_type, cmd_data, cmd_addr, cmd_cmd}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {13'd0, cmd_valid, cmd_type, cmd_data, cmd_addr, cmd_cmd}, 32'd0);

        // R12: stray bits and end with no open frame
        for (int i = 0; i < 6; i++) begin
            bit_en = 1'b1; bit_val = 1'b1; @(negedge clk);
        end
        bit_en = 1'b0; frm_end = 1'b1; @(negedge clk); frm_end = 1'b0;
        chk("R12 idle end ignored", {13'd0, cmd_valid, cmd_type, cmd_data, cmd_addr, cmd_cmd}, 32'd0);

        // R5, R2: standard short, config inputs must not matter
        for (int a = 0; a < 256; a++)
            do_frame(12, 1'b0, a[3:0], a[7:4], a, 4'h0, 1'b0, "R5 R2 std short");
        // R3: corrupted check bits
        for (int a = 0; a < 256; a++)
            do_frame(12, 1'b0, 4'h0, 4'h0, a, 4'((a % 15) + 1), 1'b0, "R3 std short bad crc");
        // R6: enhanced 12-bit with programmed poly/seed
        for (int a = 0; a < 256; a++)
            do_frame(12, 1'b1, a[3:0], a[7:4] ^ a[3:0], a, 4'h0, 1'b0, "R6 R2 enh short8");
        // R7: enhanced 14-bit, every optional/addr/cmd value
        for (int a = 0; a < 1024; a++)
            do_frame(14, 1'b1, a[3:0] ^ 4'h3, a[9:6], a, 4'h0, 1'b0, "R7 enh short10");
        // R4: long frames in both modes
        for (int a = 0; a < 256; a++)
            do_frame(20, a[0], a[7:4], a[3:0], {16'd0, a[7:0], a[7:0] ^ 8'h5A}, 4'h0, 1'b0,
                     "R4 long");
        for (int a = 0; a < 16; a++)
            do_frame(20, a[1], 4'h9, 4'h6, {16'd0, 16'hC3A5 ^ 16'(a * 97)}, 4'(1 << (a % 4)),
                     1'b0, "R3 long bad crc");
        // R8: malformed lengths
        do_frame(4, 1'b0, 4'h1, 4'h2, 32'h0, 4'h0, 1'b0, "R8 len 4");
        do_frame(11, 1'b0, 4'h1, 4'h2, 32'h5B, 4'h0, 1'b0, "R8 len 11");
        do_frame(13, 1'b1, 4'h7, 4'h2, 32'h1AB, 4'h0, 1'b0, "R8 len 13");
        do_frame(14, 1'b0, 4'h7, 4'h2, 32'h2CD, 4'h0, 1'b0, "R8 len 14 std");
        do_frame(15, 1'b1, 4'h3, 4'hE, 32'h6EF, 4'h0, 1'b0, "R8 len 15");
        do_frame(19, 1'b0, 4'h3, 4'hE, 32'h7ABC, 4'h0, 1'b0, "R8 len 19");
        do_frame(21, 1'b1, 4'h5, 4'h8, 32'h1ABCD, 4'h0, 1'b0, "R8 len 21");
        do_frame(24, 1'b0, 4'h5, 4'h8, 32'hFABCD, 4'h0, 1'b0, "R8 len 24");
        // R11: config changed mid-frame
        for (int a = 0; a < 16; a++) begin
            do_frame(14, 1'b1, 4'(a), 4'(15 - a), 32'(a * 37), 4'h0, 1'b1, "R11 enh short10");
            do_frame(12, 1'b0, 4'(a), 4'(a), 32'(a * 11), 4'h0, 1'b1, "R11 std short");
            do_frame(20, 1'b1, 4'(a), 4'h5, 32'(a * 4099), 4'h0, 1'b1, "R11 long");
        end
        // R10: aborted frame followed by a fresh one
        partial(9, 1'b0);
        do_frame(12, 1'b1, 4'hB, 4'h4, 32'hE7, 4'h0, 1'b0, "R10 abort then enh short");
        partial(17, 1'b1);
        do_frame(20, 1'b0, 4'h0, 4'h0, 32'h3C96, 4'h0, 1'b0, "R10 abort then long");
        // R10: start and end in same cycle, start wins (no strobe)
        partial(12, 1'b0);
        @(negedge clk); frm_start = 1'b1; frm_end = 1'b1;
        @(negedge clk); frm_start = 1'b0; frm_end = 1'b0;
        chk("R10 start beats end", {13'd0, cmd_valid, cmd_type, cmd_data, cmd_addr, cmd_cmd},
            {13'd0, 1'b0, hold_f});
        do_frame(12, 1'b0, 4'h0, 4'h0, 32'h4D, 4'h0, 1'b0, "R10 after collision");
        // R12: after a closed frame, stray traffic ignored
        for (int i = 0; i < 12; i++) begin
            bit_en = 1'b1; bit_val = i[1]; @(negedge clk);
        end
        bit_en = 1'b0; frm_end = 1'b1; @(negedge clk); frm_end = 1'b0;
        chk("R12 stray end after frame", {13'd0, cmd_valid, cmd_type, cmd_data, cmd_addr, cmd_cmd},
            {13'd0, 1'b0, hold_f});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule